// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns a decoded memory-operand description into an address. It takes an addressing-mode code and up to two register selects. It also takes the current values of the four pointer registers (BX, BP, SI, DI), a displacement or direct offset, and the data, stack and override segment values. From these it forms a 16-bit effective address (EA). It then forms a 20-bit physical address (PA) by shifting the chosen segment left four bits and adding the EA.

One request is presented per cycle with `req_valid`. The answer appears on the registered outputs on the next clock edge and lasts one cycle. Each answer raises exactly one of three flags: a usable address (`addr_valid`), an operand that needs no memory access (`no_mem`), or a register combination the mode does not allow (`illegal_mode`). The address buses read zero unless `addr_valid` is high.

The unit is used between the instruction decoder and the bus unit. Decoding, the register file and the memory cycle are outside it.

Top module: `seg_ea_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero on that edge.
- R2: A request sampled with `req_valid` high appears on the outputs after the next rising edge. A cycle with `req_valid` low leaves all three flags and both address buses at zero after the next edge.
- R3: When `addr_valid` is high, `pa` equals (segment × 16 + `ea`) modulo 2^20.
- R4: Mode code 2 (direct) gives `ea` equal to the full 16-bit `disp`, using the data segment.
- R5: Mode code 3 (register indirect) gives `ea` equal to the selected pointer register. The pointer is selected by `reg_a_sel` with codes 0=BX, 1=BP, 2=SI, 3=DI. Only BX, SI and DI are accepted; selecting BP raises `illegal_mode`.
- R6: Mode code 4 (register relative) gives `ea` equal to the pointer selected by `reg_a_sel` (any of the four) plus the displacement.
- R7: With `disp_wide` low, only `disp[7:0]` is used, sign-extended to 16 bits, and `disp[15:8]` has no effect. With `disp_wide` high, all 16 bits are used.
- R8: Mode code 5 (based indexed) gives `ea` = base + index. The base comes from `reg_a_sel` and must be BX (0) or BP (1). The index comes from `reg_b_sel` and must be SI (2) or DI (3). Any other pairing raises `illegal_mode`.
- R9: Mode code 6 (relative based indexed) gives `ea` = base + index + displacement, with the same register limits as R8.
- R10: The EA sum wraps modulo 2^16.
- R11: When BP takes part in the address, the segment is `ss_seg`; otherwise it is `ds_seg`. When `ovr_en` is high, `ovr_seg` replaces either default.
- R12: Mode codes 0 (immediate) and 1 (register operand) raise `no_mem`, keep `addr_valid` low and leave `ea` and `pa` at zero.
- R13: On an illegal combination, or on the reserved mode code 7, `illegal_mode` is high, `addr_valid` is low, and `ea` and `pa` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing-mode code (0..7) |
| reg_a_sel | input | 2 | Pointer or base register code (0=BX,1=BP,2=SI,3=DI) |
| reg_b_sel | input | 2 | Index register code, same encoding |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit sign-extended |
| disp | input | 16 | Displacement or direct offset |
| bx_val | input | 16 | BX register value |
| bp_val | input | 16 | BP register value |
| si_val | input | 16 | SI register value |
| di_val | input | 16 | DI register value |
| ds_seg | input | 16 | Data segment value |
| ss_seg | input | 16 | Stack segment value |
| ovr_en | input | 1 | Use the override segment |
| ovr_seg | input | 16 | Override segment value |
| addr_valid | output | 1 | `ea` and `pa` hold a usable address |
| no_mem | output | 1 | The operand needs no memory access |
| illegal_mode | output | 1 | The register combination or mode is not allowed |
| ea | output | 16 | Effective address |
| pa | output | 20 | Physical address |

## Verification
Some properties hold on every cycle and are checked by assertions: the three result flags never rise together, the address buses stay zero whenever `addr_valid` is low, an idle cycle is followed by quiet outputs, the low nibble of `pa` matches that of `ea`, and register-indirect mode never produces an address from BP. Other behaviour depends on the mode and can only be shown by the bench's directed scenarios. These are the sums for each mode, sign extension of short displacements, wrap-around of both sums, the choice between stack, data and override segments, and the rejection of each forbidden register pairing.

// File: rtl/seg_ea_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes the decoder presents mode and register codes in these encodings.
package seg_ea_pkg;

    typedef enum logic [2:0] {
        AM_IMM      = 3'd0,
        AM_REG      = 3'd1,
        AM_DIRECT   = 3'd2,
        AM_RIND     = 3'd3,
        AM_RREL     = 3'd4,
        AM_BIDX     = 3'd5,
        AM_BIDX_REL = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        RS_BX = 2'd0,
        RS_BP = 2'd1,
        RS_SI = 2'd2,
        RS_DI = 2'd3
    } rsel_e;

endpackage

// File: rtl/seg_ea_operand_sel.sv
// Module: seg_ea_operand_sel
// Picks the up-to-three address terms for the requested mode and judges the
// register combination. It also reports whether BP takes part in the address.
// Assumes register codes per seg_ea_pkg. Unused terms are driven to zero.
module seg_ea_operand_sel
    import seg_ea_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DNW = 8
) (
    input  logic [2:0]    mode_i,
    input  logic [1:0]    ra_i,
    input  logic [1:0]    rb_i,
    input  logic          disp_wide_i,
    input  logic [AW-1:0] disp_i,
    input  logic [AW-1:0] bx_i,
    input  logic [AW-1:0] bp_i,
    input  logic [AW-1:0] si_i,
    input  logic [AW-1:0] di_i,
    output logic [AW-1:0] term_a_o,
    output logic [AW-1:0] term_b_o,
    output logic [AW-1:0] term_c_o,
    output logic          use_ss_o,
    output logic          mem_o,
    output logic          nomem_o,
    output logic          illegal_o
);

    localparam int EXT_W = AW - DNW;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] reg_a_val;
    logic [AW-1:0] reg_b_val;
    logic          pair_ok;

    // Purpose: widen a short displacement by copying its sign bit.
    always_comb begin
        if (disp_wide_i) disp_ext = disp_i;
        else             disp_ext = {{EXT_W{disp_i[DNW-1]}}, disp_i[DNW-1:0]};
    end

    // Purpose: fetch the value of the register each select names.
    always_comb begin
        unique case (ra_i)
            RS_BX:   reg_a_val = bx_i;
            RS_BP:   reg_a_val = bp_i;
            RS_SI:   reg_a_val = si_i;
            default: reg_a_val = di_i;
        endcase
        unique case (rb_i)
            RS_BX:   reg_b_val = bx_i;
            RS_BP:   reg_b_val = bp_i;
            RS_SI:   reg_b_val = si_i;
            default: reg_b_val = di_i;
        endcase
    end

    // Purpose: a base must be BX or BP and an index must be SI or DI.
    assign pair_ok = (ra_i == RS_BX || ra_i == RS_BP) &&
                     (rb_i == RS_SI || rb_i == RS_DI);

    // Purpose: route terms and classify the request by mode.
    always_comb begin
        term_a_o  = '0;
        term_b_o  = '0;
        term_c_o  = '0;
        use_ss_o  = 1'b0;
        mem_o     = 1'b0;
        nomem_o   = 1'b0;
        illegal_o = 1'b0;
        case (mode_i)
            AM_IMM, AM_REG: nomem_o = 1'b1;
            AM_DIRECT: begin
                term_a_o = disp_i;
                mem_o    = 1'b1;
            end
            AM_RIND: begin
                if (ra_i == RS_BP) begin
                    illegal_o = 1'b1;
                end else begin
                    term_a_o = reg_a_val;
                    mem_o    = 1'b1;
                end
            end
            AM_RREL: begin
                term_a_o = reg_a_val;
                term_c_o = disp_ext;
                use_ss_o = (ra_i == RS_BP);
                mem_o    = 1'b1;
            end
            AM_BIDX, AM_BIDX_REL: begin
                if (!pair_ok) begin
                    illegal_o = 1'b1;
                end else begin
                    term_a_o = reg_a_val;
                    term_b_o = reg_b_val;
                    term_c_o = (mode_i == AM_BIDX_REL) ? disp_ext : '0;
                    use_ss_o = (ra_i == RS_BP);
                    mem_o    = 1'b1;
                end
            end
            default: illegal_o = 1'b1;
        endcase
    end

    // Purpose: register indirect must never yield an address from BP (R5).
    always_comb begin
        if (mode_i == AM_RIND && mem_o) begin
            a_r5_no_bp_indirect: assert (ra_i != RS_BP);
        end
    end

endmodule

// File: rtl/seg_ea_seg_mux.sv
// Module: seg_ea_seg_mux
// Chooses the segment value: the override wins, otherwise stack when BP is
// involved, otherwise data. Assumes all segment inputs are stable with the request.
module seg_ea_seg_mux #(
    parameter int AW = 16
) (
    input  logic          use_ss_i,
    input  logic          ovr_en_i,
    input  logic [AW-1:0] ds_i,
    input  logic [AW-1:0] ss_i,
    input  logic [AW-1:0] ovr_i,
    output logic [AW-1:0] seg_o
);

    // Purpose: priority pick of the segment source.
    always_comb begin
        if (ovr_en_i)      seg_o = ovr_i;
        else if (use_ss_i) seg_o = ss_i;
        else               seg_o = ds_i;
    end

endmodule

// File: rtl/seg_ea_adder.sv
// Module: seg_ea_adder
// Adds the three EA terms with wrap at AW bits, then adds the segment shifted
// left by SHIFT bits with wrap at AW+SHIFT bits. Purely combinational.
module seg_ea_adder #(
    parameter int AW    = 16,
    parameter int SHIFT = 4
) (
    input  logic [AW-1:0]       term_a_i,
    input  logic [AW-1:0]       term_b_i,
    input  logic [AW-1:0]       term_c_i,
    input  logic [AW-1:0]       seg_i,
    output logic [AW-1:0]       ea_o,
    output logic [AW+SHIFT-1:0] pa_o
);

    localparam int PAW = AW + SHIFT;

    logic [PAW-1:0] seg_base;
    logic [PAW-1:0] ea_wide;

    // Purpose: effective address, carries beyond AW bits discarded.
    assign ea_o = term_a_i + term_b_i + term_c_i;

    // Purpose: place segment and offset in the physical address space.
    assign seg_base = {seg_i, {SHIFT{1'b0}}};
    assign ea_wide  = {{SHIFT{1'b0}}, ea_o};
    assign pa_o     = seg_base + ea_wide;

endmodule

// File: rtl/seg_ea_unit.sv
// Module: seg_ea_unit (top)
// Registers one address result per request. Outputs are a one-cycle answer to
// req_valid and are quiet otherwise. Address buses are zero unless addr_valid.
// Assumes synchronous active-low reset and inputs stable around the rising edge.
module seg_ea_unit #(
    parameter int AW    = 16,
    parameter int SHIFT = 4,
    parameter int DNW   = 8,
    parameter int PAW   = AW + SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [2:0]     mode,
    input  logic [1:0]     reg_a_sel,
    input  logic [1:0]     reg_b_sel,
    input  logic           disp_wide,
    input  logic [AW-1:0]  disp,
    input  logic [AW-1:0]  bx_val,
    input  logic [AW-1:0]  bp_val,
    input  logic [AW-1:0]  si_val,
    input  logic [AW-1:0]  di_val,
    input  logic [AW-1:0]  ds_seg,
    input  logic [AW-1:0]  ss_seg,
    input  logic           ovr_en,
    input  logic [AW-1:0]  ovr_seg,
    output logic           addr_valid,
    output logic           no_mem,
    output logic           illegal_mode,
    output logic [AW-1:0]  ea,
    output logic [PAW-1:0] pa
);

    logic [AW-1:0]  t_a, t_b, t_c;
    logic           use_ss, is_mem, is_nomem, is_ill;
    logic [AW-1:0]  seg_sel;
    logic [AW-1:0]  ea_comb;
    logic [PAW-1:0] pa_comb;

    seg_ea_operand_sel #(.AW(AW), .DNW(DNW)) opsel_i (
        .mode_i      (mode),
        .ra_i        (reg_a_sel),
        .rb_i        (reg_b_sel),
        .disp_wide_i (disp_wide),
        .disp_i      (disp),
        .bx_i        (bx_val),
        .bp_i        (bp_val),
        .si_i        (si_val),
        .di_i        (di_val),
        .term_a_o    (t_a),
        .term_b_o    (t_b),
        .term_c_o    (t_c),
        .use_ss_o    (use_ss),
        .mem_o       (is_mem),
        .nomem_o     (is_nomem),
        .illegal_o   (is_ill)
    );

    seg_ea_seg_mux #(.AW(AW)) segmux_i (
        .use_ss_i (use_ss),
        .ovr_en_i (ovr_en),
        .ds_i     (ds_seg),
        .ss_i     (ss_seg),
        .ovr_i    (ovr_seg),
        .seg_o    (seg_sel)
    );

    seg_ea_adder #(.AW(AW), .SHIFT(SHIFT)) adder_i (
        .term_a_i (t_a),
        .term_b_i (t_b),
        .term_c_i (t_c),
        .seg_i    (seg_sel),
        .ea_o     (ea_comb),
        .pa_o     (pa_comb)
    );

    // Purpose: capture one result per request; stay quiet when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            addr_valid   <= 1'b0;
            no_mem       <= 1'b0;
            illegal_mode <= 1'b0;
            ea           <= '0;
            pa           <= '0;
        end else begin
            addr_valid   <= is_mem;
            no_mem       <= is_nomem;
            illegal_mode <= is_ill;
            ea           <= is_mem ? ea_comb : '0;
            pa           <= is_mem ? pa_comb : '0;
        end
    end

    // Purpose: at most one result flag at a time (R12, R13).
    a_r13_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, no_mem, illegal_mode}));

    // Purpose: address buses are zero without a valid address (R12, R13).
    a_r13_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (ea == '0 && pa == '0));

    // Purpose: an idle cycle leaves quiet outputs after the edge (R2).
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !no_mem && !illegal_mode));

    // Purpose: the shifted segment cannot touch the low SHIFT bits (R3).
    a_r3_low_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (pa[SHIFT-1:0] == ea[SHIFT-1:0]));

endmodule

// File: tb/seg_ea_unit_tb_top.sv
module seg_ea_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  mode;
    logic [1:0]  reg_a_sel, reg_b_sel;
    logic        disp_wide;
    logic [15:0] disp, bx_val, bp_val, si_val, di_val, ds_seg, ss_seg, ovr_seg;
    logic        ovr_en;
    logic        addr_valid, no_mem, illegal_mode;
    logic [15:0] ea;
    logic [19:0] pa;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    seg_ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .reg_a_sel(reg_a_sel), .reg_b_sel(reg_b_sel), .disp_wide(disp_wide),
        .disp(disp), .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val),
        .di_val(di_val), .ds_seg(ds_seg), .ss_seg(ss_seg), .ovr_en(ovr_en),
        .ovr_seg(ovr_seg), .addr_valid(addr_valid), .no_mem(no_mem),
        .illegal_mode(illegal_mode), .ea(ea), .pa(pa)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic int regv(input logic [1:0] c);
        case (c)
            2'd0: return int'(bx_val);
            2'd1: return int'(bp_val);
            2'd2: return int'(si_val);
            default: return int'(di_val);
        endcase
    endfunction

    // Drive one request, wait for the registered answer, compare with the model.
    task automatic run_case(input string req, input logic [2:0] m, input logic [1:0] a,
                            input logic [1:0] b, input logic w, input logic [15:0] d,
                            input logic oe, input logic [15:0] os);
        int dx, ev, en, ei, eea, epa, seg;
        logic bp_used;
        mode = m; reg_a_sel = a; reg_b_sel = b; disp_wide = w; disp = d;
        ovr_en = oe; ovr_seg = os; req_valid = 1'b1;
        dx = w ? int'(d) : int'({{8{d[7]}}, d[7:0]});
        ev = 0; en = 0; ei = 0; eea = 0; bp_used = 1'b0;
        case (m)
            3'd0, 3'd1: en = 1;
            3'd2: begin ev = 1; eea = int'(d); end
            3'd3: if (a == 2'd1) ei = 1; else begin ev = 1; eea = regv(a); end
            3'd4: begin ev = 1; eea = regv(a) + dx; bp_used = (a == 2'd1); end
            3'd5, 3'd6: begin
                if (a > 2'd1 || b < 2'd2) ei = 1;
                else begin
                    ev = 1; eea = regv(a) + regv(b) + ((m == 3'd6) ? dx : 0);
                    bp_used = (a == 2'd1);
                end
            end
            default: ei = 1;
        endcase
        eea = eea & 32'hFFFF;
        seg = oe ? int'(os) : (bp_used ? int'(ss_seg) : int'(ds_seg));
        epa = ev ? ((seg * 16 + eea) & 32'hFFFFF) : 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "addr_valid", int'(addr_valid), ev);
        chk(req, "no_mem", int'(no_mem), en);
        chk(req, "illegal_mode", int'(illegal_mode), ei);
        chk(req, "ea", int'(ea), eea);
        chk(req, "pa", int'(pa), epa);
    endtask

    task automatic t_reset();
        // R1: outputs zero after reset edges
        chk("R1", "addr_valid", int'(addr_valid), 0);
        chk("R1", "no_mem", int'(no_mem), 0);
        chk("R1", "illegal_mode", int'(illegal_mode), 0);
        chk("R1", "ea", int'(ea), 0);
        chk("R1", "pa", int'(pa), 0);
    endtask

    task automatic t_direct();
        run_case("R4", 3'd2, 2'd0, 2'd0, 1'b0, 16'h5000, 1'b0, 16'h0);
        run_case("R4", 3'd2, 2'd1, 2'd3, 1'b1, 16'hFFFF, 1'b0, 16'h0);
    endtask

    task automatic t_indirect();
        run_case("R5", 3'd3, 2'd0, 2'd0, 1'b0, 16'h00AA, 1'b0, 16'h0);
        run_case("R5", 3'd3, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0);
        run_case("R5", 3'd3, 2'd3, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0);
        run_case("R5", 3'd3, 2'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0);
    endtask

    task automatic t_relative();
        for (int r = 0; r < 4; r++)
            run_case("R6", 3'd4, r[1:0], 2'd0, 1'b1, 16'h0050, 1'b0, 16'h0);
        // R7: short negative displacement; high byte must be ignored
        run_case("R7", 3'd4, 2'd0, 2'd0, 1'b0, 16'h12F0, 1'b0, 16'h0);
        run_case("R7", 3'd4, 2'd2, 2'd0, 1'b0, 16'hAB7F, 1'b0, 16'h0);
        run_case("R7", 3'd4, 2'd2, 2'd0, 1'b1, 16'hAB7F, 1'b0, 16'h0);
    endtask

    task automatic t_based();
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                run_case("R8", 3'd5, a[1:0], b[1:0], 1'b0, 16'h0077, 1'b0, 16'h0);
    endtask

    task automatic t_based_rel();
        run_case("R9", 3'd6, 2'd0, 2'd2, 1'b0, 16'h0050, 1'b0, 16'h0);
        run_case("R9", 3'd6, 2'd1, 2'd3, 1'b0, 16'h00FE, 1'b0, 16'h0);
        run_case("R9", 3'd6, 2'd1, 2'd2, 1'b1, 16'h8001, 1'b0, 16'h0);
        run_case("R9", 3'd6, 2'd3, 2'd2, 1'b1, 16'h0001, 1'b0, 16'h0);
    endtask

    task automatic t_wrap();
        // R10 and R3: both sums wrap
        bx_val = 16'hFFF0; si_val = 16'h0020; ds_seg = 16'hFFFF;
        run_case("R10", 3'd5, 2'd0, 2'd2, 1'b0, 16'h0000, 1'b0, 16'h0);
        run_case("R3", 3'd6, 2'd0, 2'd2, 1'b1, 16'hFFFF, 1'b0, 16'h0);
        bx_val = 16'h1234; si_val = 16'h0456; ds_seg = 16'h2000;
    endtask

    task automatic t_segments();
        // R11: stack segment when BP involved, data otherwise, override wins
        run_case("R11", 3'd4, 2'd1, 2'd0, 1'b0, 16'h0004, 1'b0, 16'h0);
        run_case("R11", 3'd5, 2'd1, 2'd2, 1'b0, 16'h0000, 1'b0, 16'h0);
        run_case("R11", 3'd4, 2'd1, 2'd0, 1'b0, 16'h0004, 1'b1, 16'h7000);
        run_case("R11", 3'd2, 2'd0, 2'd0, 1'b0, 16'h0100, 1'b1, 16'h0ABC);
    endtask

    task automatic t_nomem();
        run_case("R12", 3'd0, 2'd0, 2'd2, 1'b1, 16'h0007, 1'b0, 16'h0);
        run_case("R12", 3'd1, 2'd1, 2'd3, 1'b1, 16'h1234, 1'b1, 16'h5555);
    endtask

    task automatic t_illegal();
        run_case("R13", 3'd7, 2'd0, 2'd2, 1'b1, 16'h1000, 1'b0, 16'h0);
        run_case("R13", 3'd6, 2'd0, 2'd1, 1'b1, 16'h1000, 1'b0, 16'h0);
    endtask

    task automatic t_idle();
        // R2: result lasts one cycle, then outputs go quiet
        run_case("R2", 3'd2, 2'd0, 2'd0, 1'b1, 16'h4321, 1'b0, 16'h0);
        @(negedge clk);
        chk("R2", "addr_valid idle", int'(addr_valid), 0);
        chk("R2", "ea idle", int'(ea), 0);
        chk("R2", "pa idle", int'(pa), 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; mode = 3'd0; reg_a_sel = 2'd0; reg_b_sel = 2'd0;
        disp_wide = 1'b0; disp = 16'h0; ovr_en = 1'b0; ovr_seg = 16'h0;
        bx_val = 16'h1234; bp_val = 16'h0800; si_val = 16'h0456; di_val = 16'hF00D;
        ds_seg = 16'h2000; ss_seg = 16'h3000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_indirect();
        t_relative();
        t_based();
        t_based_rel();
        t_wrap();
        t_segments();
        t_nomem();
        t_illegal();
        t_idle();
        // R1: reset clears a pending result
        req_valid = 1'b1; mode = 3'd2; disp = 16'h1111; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        t_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule